// File: doc/BRIEF.md
# External Interrupt Trigger Detector

This block watches 24 external request pins and decides, per pin, whether a request is present. Each pin is brought into the clock domain through two flip-flops. A 3-bit trigger field then selects what counts as a request for that pin: a low level, a high level, a falling edge, a rising edge or either edge.

Lines 0 to 3 are special. Each of them drives its own request output toward the main interrupt controller, and none of them is recorded in the pending register. Lines 4 to 23 set bits in a pending register. Software clears those bits by writing 1 to them. Each line also has a bit in a mask register. The unmasked pending bits of lines 4 to 7 are merged into one grouped request, and those of lines 8 to 23 into a second grouped request.

Software reaches the trigger fields, the mask and the pending bits through a simple register port. Writes take effect on the clock edge. Reads are combinational.

Top module: `ext_irq_detect`

## Requirements
- R1: After reset, mask bits 23..4 read 1, all pending bits read 0, all trigger fields read 0, and both grouped requests are low.
- R2: The trigger field of line i sits in bits [4k+2:4k] of the trigger register for its group of eight lines, where k = i mod 8. The register for lines 0-7 is at 0x88, for lines 8-15 at 0x8C, and for lines 16-23 at 0x90. Bit 4k+3 of each nibble reads 0.
- R3: The trigger codes are: 000 = low level, 001 = high level, 010/011 = falling edge, 100/101 = rising edge, 110/111 = both edges. Each line uses its own code.
- R4: A pin change first shows at the detector on the second rising clock edge after the change. An edge request on a direct output lasts exactly one cycle.
- R5: direct_req_o[3:0] carries the request of lines 0-3. Pending bits 3..0 always read 0.
- R6: The pending register is at 0x08, and bit n belongs to line n. A request sets the bit. Writing 1 clears it. Writing 0 has no effect. An edge-set bit stays set until it is cleared.
- R7: In the level modes, the pending bit is set again on every cycle in which the pin is at its active level. Setting wins over a clear written in the same cycle.
- R8: The mask register is at 0xA4, and bit n belongs to line n. Bits 3..0 read 0 and ignore writes.
- R9: grp_lo_req_o is the OR over lines 4-7 of (pending AND NOT mask). grp_hi_req_o is the same OR over lines 8-23.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 24 | External request pins |
| reg_addr | input | 8 | Register byte address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| direct_req_o | output | 4 | Requests of lines 0-3 |
| grp_lo_req_o | output | 1 | Grouped request of lines 4-7 |
| grp_hi_req_o | output | 1 | Grouped request of lines 8-23 |

## Verification
The bench rotates the trigger codes so that, over eight rounds, every line runs in every one of the eight codes. In each round it applies several pairs of pin vectors, including all-zero to all-one, the reverse, and pseudo-random pairs. Level modes and the three edge kinds differ on the same pin transition, so a misdecoded code or a misplaced field shows up as wrong pending bits. The direct outputs are sampled on the two cycles after a change, which separates the latency of the synchronizer and the one-cycle edge pulse from a held level. Pseudo-random masks, combined with the expected pending values, exercise both grouped OR trees. Directed steps cover write-0 to the pending register, partial clears, a set that wins over a clear, and the reserved bits.

// File: rtl/ext_irq_detect.sv
module ext_irq_detect #(
  parameter int NUM_LINES = 24,
  parameter int DIRECT = 4,
  parameter int LO_END = 7,
  parameter int LINES_PER_REG = 8,
  parameter int FIELD_STRIDE = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] PEND_OFS = 'h08,
  parameter logic [ADDR_W-1:0] MASK_OFS = 'hA4,
  parameter logic [ADDR_W-1:0] TRIG_BASE = 'h88
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_LINES-1:0] pin_i,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [DIRECT-1:0] direct_req_o,
  output logic              grp_lo_req_o,
  output logic              grp_hi_req_o
);
  localparam logic [NUM_LINES-1:0] ALL_ONES = {NUM_LINES{1'b1}};
  localparam logic [NUM_LINES-1:0] LATCH_BITS = ALL_ONES << DIRECT;
  localparam logic [NUM_LINES-1:0] LO_BITS = LATCH_BITS & (ALL_ONES >> (NUM_LINES - 1 - LO_END));
  localparam logic [NUM_LINES-1:0] HI_BITS = LATCH_BITS & ~LO_BITS;

  logic [NUM_LINES-1:0] sync1, sync2, prev;
  logic [NUM_LINES-1:0] hit, pend_q, mask_q, clr;
  logic [3*NUM_LINES-1:0] mode_q;
  logic unused_wdata;

  assign unused_wdata = ^reg_wdata[DATA_W-1:NUM_LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
    end else begin
      sync1 <= pin_i;
      sync2 <= sync1;
      prev  <= sync2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (reg_wr) begin
      for (int i = 0; i < NUM_LINES; i++) begin
        if (reg_addr == TRIG_BASE + ADDR_W'(4 * (i / LINES_PER_REG)))
          mode_q[3*i +: 3] <= reg_wdata[FIELD_STRIDE*(i % LINES_PER_REG) +: 3];
      end
    end
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic [2:0] md;
    assign md = mode_q[3*g +: 3];
    assign hit[g] = (md == 3'b000)      ? ~sync2[g] :
                    (md == 3'b001)      ?  sync2[g] :
                    (md[2:1] == 2'b01)  ? (prev[g] & ~sync2[g]) :
                    (md[2:1] == 2'b10)  ? (~prev[g] & sync2[g]) :
                                          (prev[g] ^ sync2[g]);
  end

  assign clr = (reg_wr && reg_addr == PEND_OFS) ? reg_wdata[NUM_LINES-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= LATCH_BITS;
    end else begin
      pend_q <= ((pend_q & ~clr) | hit) & LATCH_BITS;
      if (reg_wr && reg_addr == MASK_OFS)
        mask_q <= reg_wdata[NUM_LINES-1:0] & LATCH_BITS;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == PEND_OFS) reg_rdata[NUM_LINES-1:0] = pend_q;
    if (reg_addr == MASK_OFS) reg_rdata[NUM_LINES-1:0] = mask_q;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (reg_addr == TRIG_BASE + ADDR_W'(4 * (i / LINES_PER_REG)))
        reg_rdata[FIELD_STRIDE*(i % LINES_PER_REG) +: 3] = mode_q[3*i +: 3];
    end
  end

  assign direct_req_o = hit[DIRECT-1:0];
  assign grp_lo_req_o = |(pend_q & ~mask_q & LO_BITS);
  assign grp_hi_req_o = |(pend_q & ~mask_q & HI_BITS);
endmodule

// File: rtl/ext_irq_detect_chk.sv
module ext_irq_detect_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  reg_addr,
  input logic        reg_wr,
  input logic [23:0] reg_wdata,
  input logic [3:0]  rdata_lo,
  input logic [23:0] pend,
  input logic [23:4] mask,
  input logic        grp_lo,
  input logic        grp_hi
);
  logic unused_wdata;
  assign unused_wdata = ^reg_wdata[3:0];

  AST_PEND_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 8'h08) |-> (rdata_lo == 4'h0)); // R5

  AST_MASK_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 8'hA4) |-> (rdata_lo == 4'h0)); // R8

  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!(reg_wr && reg_addr == 8'h08)) |=> ((pend & $past(pend)) == $past(pend))); // R6

  AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 8'hA4) |=> (mask == $past(reg_wdata[23:4]))); // R8

  AST_GRP_LO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask[7:4]) |-> !grp_lo); // R9

  AST_GRP_HI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask[23:8]) |-> !grp_hi); // R9
endmodule

bind ext_irq_detect ext_irq_detect_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata[23:0]), .rdata_lo(reg_rdata[3:0]), .pend(pend_q),
  .mask(mask_q[23:4]), .grp_lo(grp_lo_req_o), .grp_hi(grp_hi_req_o)
);

// File: tb/ext_irq_detect_test.sv
`timescale 1ns/1ps
module ext_irq_detect_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] pin_i = '0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  direct_req_o;
  logic        grp_lo_req_o, grp_hi_req_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  ext_irq_detect uut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .direct_req_o(direct_req_o), .grp_lo_req_o(grp_lo_req_o),
    .grp_hi_req_o(grp_hi_req_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  function automatic bit lvl_act(int m, bit v);
    return (m == 0) ? !v : v;
  endfunction

  function automatic bit edge_hit(int m, bit a, bit b);
    case (m / 2)
      1: return a & !b;
      2: return !a & b;
      default: return a ^ b;
    endcase
  endfunction

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] lcg;
    lcg = 32'h1234_5678;
    step(3);
    // R1 reset state, read while reset is held
    rd(8'hA4, d); chk("R1", "mask reset", d, 32'h00FF_FFF0);
    rd(8'h08, d); chk("R1", "pending reset", d, 32'h0);
    rd(8'h88, d); chk("R1", "trig0 reset", d, 32'h0);
    rd(8'h90, d); chk("R1", "trig2 reset", d, 32'h0);
    chk("R1", "groups reset", {30'd0, grp_hi_req_o, grp_lo_req_o}, 32'h0);
    rst_n = 1'b1;
    step(2);

    // R2 field placement and reserved nibble bit
    wr(8'h8C, 32'hFFFF_FFFF);
    rd(8'h8C, d); chk("R2", "trig1 reserved bits", d, 32'h7777_7777);
    rd(8'h88, d); chk("R2", "trig0 untouched", d, 32'h0);
    wr(8'h8C, 32'h0);

    // R8 mask reserved bits
    wr(8'hA4, 32'hFFFF_FFFF);
    rd(8'hA4, d); chk("R8", "mask all ones", d, 32'h00FF_FFF0);
    wr(8'hA4, 32'h0);
    rd(8'hA4, d); chk("R8", "mask cleared", d, 32'h0);

    // R3 R4 R5 R6 R9 sweep: every line runs every code
    for (int it = 0; it < 8; it++) begin
      for (int pat = 0; pat < 4; pat++) begin
        logic [23:0] p0, p1, msk, exp_pend;
        logic [3:0] exp_d1, exp_d2;
        int mode [24];
        logic [31:0] tv;
        lcg = lcg * 32'd1103515245 + 32'd12345; p0 = lcg[31:8];
        lcg = lcg * 32'd1103515245 + 32'd12345; p1 = lcg[31:8];
        lcg = lcg * 32'd1103515245 + 32'd12345; msk = lcg[31:8] & 24'hFFFFF0;
        if (pat == 0) begin p0 = 24'h0; p1 = 24'hFFFFFF; end
        if (pat == 1) begin p0 = 24'hFFFFFF; p1 = 24'h0; end
        for (int i = 0; i < 24; i++) mode[i] = (it + i) % 8;
        for (int r = 0; r < 3; r++) begin
          tv = '0;
          for (int k = 0; k < 8; k++) tv[4*k +: 3] = 3'(mode[8*r + k]);
          wr(8'h88 + 8'(4 * r), tv);
        end
        wr(8'hA4, {8'h0, msk});
        exp_pend = '0; exp_d1 = '0; exp_d2 = '0;
        for (int i = 0; i < 24; i++) begin
          if (mode[i] <= 1) begin
            if (i >= 4) exp_pend[i] = lvl_act(mode[i], p0[i]) | lvl_act(mode[i], p1[i]);
            if (i < 4) begin
              exp_d1[i] = lvl_act(mode[i], p1[i]);
              exp_d2[i] = lvl_act(mode[i], p1[i]);
            end
          end else begin
            if (i >= 4) exp_pend[i] = edge_hit(mode[i], p0[i], p1[i]);
            if (i < 4) exp_d1[i] = edge_hit(mode[i], p0[i], p1[i]);
          end
        end
        pin_i = p0;
        step(4);
        wr(8'h08, 32'h00FF_FFFF);
        pin_i = p1;
        step(1);
        step(1);
        chk("R4", "direct after second edge", {28'd0, direct_req_o}, {28'd0, exp_d1});
        step(1);
        chk("R4", "direct one cycle later", {28'd0, direct_req_o}, {28'd0, exp_d2});
        step(2);
        rd(8'h08, d);
        chk("R3", $sformatf("pending it=%0d pat=%0d", it, pat), d, {8'h0, exp_pend});
        chk("R5", "pending low bits", {28'd0, d[3:0]}, 32'h0);
        chk("R9", "grp_lo", {31'd0, grp_lo_req_o}, {31'd0, |(exp_pend[7:4] & ~msk[7:4])});
        chk("R9", "grp_hi", {31'd0, grp_hi_req_o}, {31'd0, |(exp_pend[23:8] & ~msk[23:8])});
      end
    end

    // R6 edge hold, write-0 no effect, partial clear
    wr(8'h88, 32'h4444_4444); wr(8'h8C, 32'h4444_4444); wr(8'h90, 32'h4444_4444);
    pin_i = 24'h0; step(4);
    wr(8'h08, 32'hFFFF_FFFF);
    pin_i = 24'hFFFFFF; step(5);
    rd(8'h08, d); chk("R6", "rising all set", d, 32'h00FF_FFF0);
    wr(8'h08, 32'h0); step(1);
    rd(8'h08, d); chk("R6", "write 0 no effect", d, 32'h00FF_FFF0);
    wr(8'h08, 32'h0000_0010); step(2);
    rd(8'h08, d); chk("R6", "partial clear holds", d, 32'h00FF_FFE0);

    // R7 level set wins over clear
    wr(8'h88, 32'h1111_1111); wr(8'h8C, 32'h1111_1111); wr(8'h90, 32'h1111_1111);
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, d); chk("R7", "level re-asserts", d, 32'h00FF_FFF0);
    chk("R5", "direct high level", {28'd0, direct_req_o}, 32'hF);
    pin_i = 24'h0; step(3);
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, d); chk("R7", "level cleared when inactive", d, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule